// File: doc/BRIEF.md
# Open-Row SDRAM Command Generator

This block sits between a request queue and the command pins of an SDRAM device. It accepts one read or write request at a time, with row and column already split out. It turns each request into the shortest legal command sequence under an open-row policy. A row that has been activated stays open after the access. A later request to the same row is therefore served by a single column command. A request to a different row first closes the open row and then opens the new one.

A free-running refresh timer raises a refresh request at a fixed interval. The generator serves that request only from its idle state, so the commands of a request are never split. If a row is open, it is closed with a precharge-all command first. Minimum spacings are parameters and are met with NOP cycles:

- ACTIVE to column command.
- PRECHARGE to ACTIVE or REFRESH.
- REFRESH to the next command.

A read-capture strobe marks the cycle in which read data appears, which is CAS latency cycles after READ.

The state machine has eight states. Each state has a fixed 3-bit code, given here with its exits:

- ST_IDLE = 000: decision point. It goes to ST_CLOSE_ALL or ST_REFRESH when a refresh is due. Otherwise it goes to ST_OPEN (row empty), ST_READ or ST_WRITE (row hit), or ST_CLOSE (row conflict) when a request is valid.
- ST_OPEN = 001: issues ACTIVE. It goes to ST_OPEN_WAIT, or straight to the access state when tRCD is 1.
- ST_OPEN_WAIT = 010: waits out tRCD, then goes to ST_READ or ST_WRITE.
- ST_REFRESH = 011: issues REFRESH, waits tRFC, then goes to ST_IDLE.
- ST_READ = 100 and ST_WRITE = 101: issue the column command, then go to ST_IDLE.
- ST_CLOSE = 110: issues PRECHARGE, waits tRP, then goes to ST_OPEN.
- ST_CLOSE_ALL = 111: issues precharge-all, waits tRP, then goes to ST_REFRESH.

Top module: `openrow_cmd_gen`

## Requirements
- R1: Commands on {cs_n, ras_n, cas_n, we_n} are encoded as follows: NOP = 0111, ACTIVE = 0011, READ = 0101, WRITE = 0100, PRECHARGE = 0010, REFRESH = 0001. During reset and in every cycle with no command, NOP is driven with an all-zero address, and req_ready and rd_capture are low.
- R2: A request seen in an idle cycle while no row is open produces ACTIVE in the next cycle, with the request row on sd_addr. The READ or WRITE follows exactly TRCD cycles after the ACTIVE, with NOP in between.
- R3: A request whose row equals the open row produces READ or WRITE in the cycle after the idle decision cycle, with the column on sd_addr, and no ACTIVE or PRECHARGE.
- R4: A request to a different row than the open one produces the following sequence:
  - PRECHARGE with sd_addr[AP_BIT] = 0 in the cycle after the decision.
  - ACTIVE for the new row exactly TRP cycles after the PRECHARGE.
  - The access exactly TRCD cycles after the ACTIVE.
- R5: No automatic precharge is issued. READ and WRITE carry sd_addr[AP_BIT] = 0, and the row stays open so that later requests to it are hits.
- R6: A refresh becomes due every REF_INTERVAL cycles and is served from idle, as follows:
  - If a row is open, precharge-all (PRECHARGE with sd_addr[AP_BIT] = 1) is issued first, then REFRESH TRP cycles later.
  - If no row is open, REFRESH is issued directly.
  - After REFRESH, only NOP is driven for TRFC cycles in total.
- R7: After a refresh no row is open, so the next request is handled as row empty.
- R8: A refresh that is due in an idle cycle takes priority over a valid request. The command sequence of a request is never split by a refresh.
- R9: rd_capture is high for one cycle, exactly CAS_LAT cycles after each READ command, and never after WRITE.
- R10: req_ready is high exactly in the cycle of the READ or WRITE command of a request, once per request. The request fields are sampled in the idle decision cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_ready | output | 1 | Request consumed (column command cycle) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row, column or precharge-all flag |
| rd_capture | output | 1 | Read data valid on the data pins this cycle |

## Verification
The request stream is built from several patterns:

- Runs of three requests to one row, which separate the row-hit path from the row-empty and row-conflict paths.
- Rows that alternate on every request, which exercise PRECHARGE-to-ACTIVE spacing back to back.
- Mixed reads and writes, which show that rd_capture follows only READ.
- Short gaps, which let refresh fall both before and after a waiting request, checking its priority and that no sequence is split.
- An idle period longer than two refresh intervals, which separates refresh with a row open (precharge-all first) from refresh with the bank already closed.

The reference model predicts the command, address, ready and capture on every clock, so any spacing that is off by one cycle is caught.

// File: rtl/orcg_pkg.sv
package orcg_pkg;

    // State codes are fixed; see brief.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'b000,
        ST_OPEN      = 3'b001,
        ST_OPEN_WAIT = 3'b010,
        ST_REFRESH   = 3'b011,
        ST_READ      = 3'b100,
        ST_WRITE     = 3'b101,
        ST_CLOSE     = 3'b110,
        ST_CLOSE_ALL = 3'b111
    } gen_state_e;

    typedef enum logic [1:0] {
        ROW_EMPTY    = 2'd0,
        ROW_HIT      = 2'd1,
        ROW_CONFLICT = 2'd2
    } row_class_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP   = 4'b0111;
    localparam sdr_cmd_t CMD_ACT   = 4'b0011;
    localparam sdr_cmd_t CMD_READ  = 4'b0101;
    localparam sdr_cmd_t CMD_WRITE = 4'b0100;
    localparam sdr_cmd_t CMD_PRE   = 4'b0010;
    localparam sdr_cmd_t CMD_REF   = 4'b0001;

endpackage

// File: rtl/orcg_row_track.sv
module orcg_row_track
    import orcg_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic             access_i,
    input  logic [ROW_W-1:0] open_row_i,
    input  logic [ROW_W-1:0] req_row_i,
    output logic             row_open_o,
    output row_class_e       class_o
);

    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (close_i) begin
            open_q <= 1'b0;
        end else if (open_i) begin
            open_q <= 1'b1;
            row_q  <= open_row_i;
        end
    end

    always_comb begin
        if (!open_q) begin
            class_o = ROW_EMPTY;
        end else if (row_q == req_row_i) begin
            class_o = ROW_HIT;
        end else begin
            class_o = ROW_CONFLICT;
        end
    end

    assign row_open_o = open_q;

    // R2
    act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_i |-> !open_q);

    // R4
    close_only_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |-> open_q);

    // R3
    access_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_i |-> open_q);

endmodule

// File: rtl/orcg_wait_timer.sv
module orcg_wait_timer #(
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/orcg_refresh_timer.sv
module orcg_refresh_timer #(
    parameter int INTERVAL = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);

    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
            if (wrap) begin
                pend_q <= 1'b1;
            end else if (ack_i) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign pend_o = pend_q;

    // R6
    refresh_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> pend_q);

endmodule

// File: rtl/openrow_cmd_gen.sv
module openrow_cmd_gen
    import orcg_pkg::*;
#(
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int AP_BIT       = 10,
    parameter int TRCD         = 2,
    parameter int TRP          = 2,
    parameter int CAS_LAT      = 2,
    parameter int TRFC         = 4,
    parameter int REF_INTERVAL = 780
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_ready,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [ROW_W-1:0] sd_addr,
    output logic             rd_capture
);

    localparam int T_MAX   = (TRCD > TRP) ? ((TRCD > TRFC) ? TRCD : TRFC)
                                          : ((TRP > TRFC) ? TRP : TRFC);
    localparam int TW      = $clog2(T_MAX + 1);
    localparam int TRCD_LD = (TRCD >= 2) ? TRCD - 2 : 0;
    localparam int TRP_LD  = (TRP >= 2) ? TRP - 2 : 0;
    localparam int TRFC_LD = (TRFC >= 2) ? TRFC - 2 : 0;
    localparam int CHK_W   = 8;

    gen_state_e       state_q, state_d, access_st;
    logic             entry_q;
    logic             take_req;
    logic             wr_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             row_open;
    row_class_e       row_class;
    logic             ref_pend;
    logic             t_load;
    logic [TW-1:0]    t_val;
    logic             t_zero;
    logic             act_now, pre_now, ref_now, rd_now, acc_now;
    sdr_cmd_t         cmd;

    orcg_row_track #(.ROW_W(ROW_W)) row_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_i     (act_now),
        .close_i    (pre_now),
        .access_i   (acc_now),
        .open_row_i (row_q),
        .req_row_i  (req_row),
        .row_open_o (row_open),
        .class_o    (row_class)
    );

    orcg_wait_timer #(.TW(TW)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    orcg_refresh_timer #(.INTERVAL(REF_INTERVAL)) ref_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (ref_now),
        .pend_o (ref_pend)
    );

    assign access_st = wr_q ? ST_WRITE : ST_READ;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        take_req = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    state_d = row_open ? ST_CLOSE_ALL : ST_REFRESH;
                end else if (req_valid) begin
                    take_req = 1'b1;
                    unique case (row_class)
                        ROW_EMPTY: state_d = ST_OPEN;
                        ROW_HIT:   state_d = req_write ? ST_WRITE : ST_READ;
                        default:   state_d = ST_CLOSE;
                    endcase
                end
            end
            ST_CLOSE: begin
                if (entry_q ? (TRP == 1) : t_zero) state_d = ST_OPEN;
            end
            ST_OPEN: begin
                state_d = (TRCD == 1) ? access_st : ST_OPEN_WAIT;
            end
            ST_OPEN_WAIT: begin
                if (t_zero) state_d = access_st;
            end
            ST_CLOSE_ALL: begin
                if (entry_q ? (TRP == 1) : t_zero) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                if (entry_q ? (TRFC == 1) : t_zero) state_d = ST_IDLE;
            end
            ST_READ, ST_WRITE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            entry_q <= 1'b0;
            wr_q    <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d != state_q);
            if (take_req) begin
                wr_q  <= req_write;
                row_q <= req_row;
                col_q <= req_col;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        act_now   = 1'b0;
        pre_now   = 1'b0;
        ref_now   = 1'b0;
        rd_now    = 1'b0;
        acc_now   = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        req_ready = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_OPEN_WAIT: begin
                cmd = CMD_NOP;
            end
            ST_OPEN: begin
                cmd     = CMD_ACT;
                sd_addr = row_q;
                act_now = 1'b1;
                t_load  = 1'b1;
                t_val   = TW'(TRCD_LD);
            end
            ST_READ: begin
                cmd                 = CMD_READ;
                sd_addr[COL_W-1:0]  = col_q;
                rd_now              = 1'b1;
                acc_now             = 1'b1;
                req_ready           = 1'b1;
            end
            ST_WRITE: begin
                cmd                 = CMD_WRITE;
                sd_addr[COL_W-1:0]  = col_q;
                acc_now             = 1'b1;
                req_ready           = 1'b1;
            end
            ST_CLOSE: begin
                if (entry_q) begin
                    cmd     = CMD_PRE;
                    pre_now = 1'b1;
                    t_load  = 1'b1;
                    t_val   = TW'(TRP_LD);
                end
            end
            ST_CLOSE_ALL: begin
                if (entry_q) begin
                    cmd             = CMD_PRE;
                    sd_addr[AP_BIT] = 1'b1;
                    pre_now         = 1'b1;
                    t_load          = 1'b1;
                    t_val           = TW'(TRP_LD);
                end
            end
            ST_REFRESH: begin
                if (entry_q) begin
                    cmd     = CMD_REF;
                    ref_now = 1'b1;
                    t_load  = 1'b1;
                    t_val   = TW'(TRFC_LD);
                end
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    // Read data strobe, CAS_LAT cycles after READ
    logic [CAS_LAT-1:0] rd_pipe;
    generate
        if (CAS_LAT == 1) begin : g_cl_one
            always_ff @(posedge clk) begin
                if (!rst_n) rd_pipe <= '0;
                else        rd_pipe <= rd_now;
            end
        end else begin : g_cl_multi
            always_ff @(posedge clk) begin
                if (!rst_n) rd_pipe <= '0;
                else        rd_pipe <= {rd_pipe[CAS_LAT-2:0], rd_now};
            end
        end
    endgenerate
    assign rd_capture = rd_pipe[CAS_LAT-1];

    // Spacing monitors for the assertions
    logic [CHK_W-1:0] since_act, since_pre, since_ref;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '1;
            since_pre <= '1;
            since_ref <= '1;
        end else begin
            since_act <= act_now ? CHK_W'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
            since_pre <= pre_now ? CHK_W'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
            since_ref <= ref_now ? CHK_W'(1) : ((since_ref == '1) ? since_ref : since_ref + 1'b1);
        end
    end

    // R2
    trcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> (since_act >= CHK_W'(TRCD)));

    // R4
    trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n) |-> (since_pre >= CHK_W'(TRP)));

    // R6
    refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> (since_ref >= CHK_W'(TRFC)));

    // R6
    refresh_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_now |-> (!row_open && since_pre >= CHK_W'(TRP)));

    // R10
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

// File: tb/openrow_cmd_gen_tb_top.sv
`timescale 1ns/1ps
module openrow_cmd_gen_tb_top;

    localparam int ROW_W        = 13;
    localparam int COL_W        = 10;
    localparam int AP_BIT       = 10;
    localparam int TRCD         = 3;
    localparam int TRP          = 2;
    localparam int CAS_LAT      = 3;
    localparam int TRFC         = 4;
    localparam int REF_INTERVAL = 50;
    localparam int NREQ         = 80;
    localparam int WATCHDOG     = 20000;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, req_write;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_capture;
    logic [ROW_W-1:0] sd_addr;

    always #2 clk = ~clk;

    openrow_cmd_gen #(
        .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .TRCD(TRCD), .TRP(TRP),
        .CAS_LAT(CAS_LAT), .TRFC(TRFC), .REF_INTERVAL(REF_INTERVAL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .req_col(req_col), .req_ready(req_ready),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .rd_capture(rd_capture)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [3:0]       q_cmd[$];
    logic [ROW_W-1:0] q_addr[$];
    bit               q_rdy[$];
    string            q_tag[$];
    int               cap_q[$];
    bit               m_open = 0;
    int               m_row = 0;
    bit               m_pend = 0;
    int               m_refcnt = 0;
    bit               m_after_ref = 0;
    int               cyc = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [ROW_W-1:0] a,
                        input bit r, input string tag);
        q_cmd.push_back(c); q_addr.push_back(a); q_rdy.push_back(r); q_tag.push_back(tag);
    endtask

    task automatic push_nops(input int n, input string tag);
        for (int k = 0; k < n; k++) push(C_NOP, '0, 1'b0, tag);
    endtask

    function automatic logic [ROW_W-1:0] row_of(input int i);
        return (i >= 60) ? ROW_W'((i % 2) * 3 + 2) : ROW_W'(((i / 3) % 4) * 5 + 1);
    endfunction
    function automatic logic [COL_W-1:0] col_of(input int i);
        return COL_W'((i * 37) % 1024);
    endfunction
    function automatic bit wr_of(input int i);
        return (i % 3 == 1) || (i % 7 == 0);
    endfunction
    function automatic int gap_of(input int i);
        if (i == 40) return 2 * REF_INTERVAL + 10;
        return (i % 5 == 3) ? (i % 4) : 0;
    endfunction

    task automatic model_step();
        logic [3:0]       e_cmd;
        logic [ROW_W-1:0] e_addr;
        bit               e_rdy;
        bit               e_cap;
        string            tag;
        logic [ROW_W-1:0] col_addr;
        e_cap = 0;
        if (cap_q.size() > 0 && cap_q[0] == cyc) begin
            e_cap = 1;
            void'(cap_q.pop_front());
        end
        if (q_cmd.size() == 0) begin
            e_cmd = C_NOP; e_addr = '0; e_rdy = 0; tag = "R1";
            if (m_pend) begin
                string rt;
                rt = req_valid ? "R8" : "R6";
                if (m_open) begin
                    push(C_PRE, ROW_W'(1) << AP_BIT, 1'b0, rt);
                    push_nops(TRP - 1, rt);
                end
                push(C_REF, '0, 1'b0, rt);
                push_nops(TRFC - 1, rt);
                m_open = 0;
                m_after_ref = 1;
            end else if (req_valid) begin
                col_addr = '0;
                col_addr[COL_W-1:0] = req_col;
                if (!m_open) begin
                    string et;
                    et = m_after_ref ? "R7" : "R2";
                    push(C_ACT, req_row, 1'b0, et);
                    push_nops(TRCD - 1, et);
                    push(req_write ? C_WR : C_RD, col_addr, 1'b1, et);
                end else if (m_row == int'(req_row)) begin
                    push(req_write ? C_WR : C_RD, col_addr, 1'b1, "R3,R5");
                end else begin
                    push(C_PRE, '0, 1'b0, "R4");
                    push_nops(TRP - 1, "R4");
                    push(C_ACT, req_row, 1'b0, "R4");
                    push_nops(TRCD - 1, "R4");
                    push(req_write ? C_WR : C_RD, col_addr, 1'b1, "R4");
                end
                m_open = 1;
                m_row = int'(req_row);
                m_after_ref = 0;
            end
        end else begin
            e_cmd = q_cmd.pop_front(); e_addr = q_addr.pop_front();
            e_rdy = q_rdy.pop_front(); tag = q_tag.pop_front();
        end

        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e_cmd, tag, "command",
            int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e_cmd));
        chk(sd_addr == e_addr, tag, "address", int'(sd_addr), int'(e_addr));
        if (e_cmd == C_RD || e_cmd == C_WR)
            chk(sd_addr[AP_BIT] == 1'b0, "R5", "auto-precharge bit", int'(sd_addr[AP_BIT]), 0);
        chk(req_ready == e_rdy, "R10", "req_ready", int'(req_ready), int'(e_rdy));
        chk(rd_capture == e_cap, "R9", "rd_capture", int'(rd_capture), int'(e_cap));

        if (e_cmd == C_RD) cap_q.push_back(cyc + CAS_LAT);
        if (m_refcnt == REF_INTERVAL - 1) begin
            m_refcnt = 0;
            m_pend = 1;
        end else begin
            m_refcnt++;
            if (e_cmd == C_REF) m_pend = 0;
        end
        cyc++;
    endtask

    initial begin
        int  ri;
        int  gap_left;
        bit  prev_ready;
        bit  done;
        ri = 0; gap_left = 0; prev_ready = 0; done = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_row = '0; req_col = '0;
        repeat (3) begin
            @(negedge clk);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "reset command",
                int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(C_NOP));
            chk(sd_addr == '0, "R1", "reset address", int'(sd_addr), 0);
            chk(!req_ready && !rd_capture, "R1", "reset strobes",
                int'({req_ready, rd_capture}), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        while (!done) begin
            if (prev_ready) begin
                req_valid = 1'b0;
                ri++;
                gap_left = gap_of(ri);
            end
            if (!req_valid && ri < NREQ) begin
                if (gap_left > 0) begin
                    gap_left--;
                end else begin
                    req_row   = row_of(ri);
                    req_col   = col_of(ri);
                    req_write = wr_of(ri);
                    req_valid = 1'b1;
                end
            end
            model_step();
            prev_ready = req_ready;
            if (ri >= NREQ && q_cmd.size() == 0 && cap_q.size() == 0) done = 1;
            if (cyc > WATCHDOG) begin
                chk(1'b0, "R10", "watchdog expired", cyc, WATCHDOG);
                done = 1;
            end
            if (!done) @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule